// File: doc/BRIEF.md
# Dual-Clock FIFO with Spill Recovery

This block carries a stream of fixed-width words from a write clock domain into a read clock domain. Each pointer crosses to the other domain as Gray code through a two-stage synchronizer, and the full and empty decisions use the synchronized copies. After reset, and before any traffic is allowed, the storage array is swept to zero one address per write clock.

The block watches for two error conditions. An overflow is a word offered while the buffer is full. An underflow is a pull issued while it is empty. Either one is a spill. A spill sets a sticky status bit, which drives an interrupt line that can be masked. When automatic recovery is enabled, a spill also starts one of two configured actions. The first is a one-cycle realignment request to the upstream frame aligner. The second is a local flush that returns both pointers to zero. The action can be made to wait for a lock indication. A frame-alignment pulse from upstream also flushes the buffer, except in bypass mode.

Write side: a word is taken at a `wr_clk` edge when `wr_valid` and `wr_ready` are both high. `wr_ready` drops while the buffer is full, while the array is being cleared, and for a hold window after a flush. Upstream cannot be stalled. A word offered while the buffer is full is discarded. Read side: `rd_pull` is a demand strobe, not a ready. Each pull yields `rd_valid` high with a word on the next `rd_clk` edge, or `rd_valid` low if nothing was stored. All control and status pins are in the `wr_clk` domain. `rd_clk` must not run faster than `wr_clk`.

Top module: `dual_clock_spill_fifo`

## Requirements
- R1: After reset, `wr_ready` stays low for DEPTH `wr_clk` cycles while every RAM address is written with zero. During that time `rd_valid`, `rd_data`, `spill_sts` and `nfa_req` stay 0.
- R2: Every accepted word (`wr_valid` and `wr_ready` high at a `wr_clk` edge) appears exactly once, in order, on `rd_data`. It is marked by `rd_valid` high for the one `rd_clk` cycle after the edge that took the pull.
- R3: `wr_ready` is low once DEPTH words are stored and unread. A word offered then is discarded and counts as an overflow spill.
- R4: A pull while the buffer is empty gives `rd_valid` low, leaves `rd_data` unchanged, and counts as an underflow spill.
- R5: `spill_sts` goes to 1 on any spill. It stays at 1 until a `sts_clr` pulse arrives in a cycle with no new spill.
- R6: `spill_irq` follows `spill_sts` while `irq_mask` is 0, and is 0 while `irq_mask` is 1.
- R7: With `auto_en`=1 and `act_sel`=1, each spill produces one `nfa_req` pulse of one cycle, one `wr_clk` later. The stored words are unaffected.
- R8: With `auto_en`=1 and `act_sel`=0, a spill flushes the buffer. Both pointers return to zero and stored words are discarded. `wr_ready` is held low for FLUSH_HOLD cycles, and then normal transfer resumes.
- R9: With `auto_en`=0, a spill causes neither `nfa_req` nor a flush.
- R10: With `lock_gate`=1, the recovery action happens only while the selected lock input is high. That input is `rll_lock` when `async_map`=1 and `pll_lock` when `async_map`=0.
- R11: A `new_align` pulse flushes the buffer as in R8 when `bypass`=0. When `bypass`=1 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low, synchronous |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write side can take a word |
| wr_data | input | DATA_W | Write word |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low, synchronous |
| rd_pull | input | 1 | Read demand strobe |
| rd_valid | output | 1 | Word delivered for the last pull |
| rd_data | output | DATA_W | Read word, held between deliveries |
| new_align | input | 1 | Frame alignment event pulse (wr_clk) |
| bypass | input | 1 | Bypass mode, alignment events ignored |
| auto_en | input | 1 | Automatic spill recovery enable |
| act_sel | input | 1 | Recovery action: 1 realign request, 0 flush |
| lock_gate | input | 1 | Recovery only while locked |
| async_map | input | 1 | Lock source select: 1 rll_lock, 0 pll_lock |
| pll_lock | input | 1 | Lock indication for synchronous mapping |
| rll_lock | input | 1 | Lock indication for asynchronous mapping |
| irq_mask | input | 1 | Spill interrupt mask |
| sts_clr | input | 1 | Write-1 pulse clearing the spill status |
| spill_sts | output | 1 | Sticky spill status |
| spill_irq | output | 1 | Masked spill interrupt |
| nfa_req | output | 1 | Realignment request pulse |

## Verification
The assertions take the configuration pins (`auto_en`, `act_sel`, `lock_gate`, `async_map` and the lock inputs) to be steady around a spill. They also take `rd_clk` to be no faster than `wr_clk`, because the flush hold window and the underflow toggle crossing both depend on that ratio. The stimulus changes configuration only while the buffer is idle and no spill is pending. It runs the read clock at a slightly longer period than the write clock. It stops pulling before each flush, so that no word in transit is counted against a cleared expectation.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    SPILL_ACT_FLUSH   = 1'b0,
    SPILL_ACT_REALIGN = 1'b1
  } spill_act_e;

  typedef enum logic {
    LOCK_SRC_PLL = 1'b0,
    LOCK_SRC_RLL = 1'b1
  } lock_src_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned FLUSH_HOLD = 12,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     rgray_s,
  input  logic              flush,
  output logic              wr_ready,
  output logic              ovf_evt,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [PW-1:0]     wgray,
  output logic [PW-1:0]     wptr,
  output logic              init_done,
  output logic              flush_tog
);
  localparam int unsigned HW = $clog2(FLUSH_HOLD + 1);

  logic          fill_busy;
  logic [AW-1:0] fill_addr;
  logic [HW-1:0] hold;
  logic [PW-1:0] rbin;
  logic [PW-1:0] wptr_nx;
  logic          full, open, accept;

  for (genvar i = 0; i < PW; i++) begin : g_rd_g2b
    assign rbin[i] = ^(rgray_s >> i);
  end

  assign full      = (wptr[AW] != rbin[AW]) && (wptr[AW-1:0] == rbin[AW-1:0]);
  assign open      = !fill_busy && (hold == '0);
  assign wr_ready  = open && !full;
  assign accept    = wr_valid && wr_ready;
  assign ovf_evt   = wr_valid && open && full;
  assign init_done = !fill_busy;
  assign wptr_nx   = wptr + 1'b1;

  assign mem_we    = fill_busy || accept;
  assign mem_addr  = fill_busy ? fill_addr : wptr[AW-1:0];
  assign mem_wdata = fill_busy ? '0 : wr_data;

  always_ff @(posedge wr_clk) begin
    if (!wr_rst_n) begin
      fill_busy <= 1'b1;
      fill_addr <= '0;
      hold      <= '0;
      wptr      <= '0;
      wgray     <= '0;
      flush_tog <= 1'b0;
    end else begin
      if (fill_busy) begin
        fill_addr <= fill_addr + 1'b1;
        if (fill_addr == AW'(DEPTH - 1)) fill_busy <= 1'b0;
      end
      if (flush) begin
        wptr  <= '0;
        wgray <= '0;
        hold  <= HW'(FLUSH_HOLD);
        if (hold == '0) flush_tog <= ~flush_tog;
      end else begin
        if (hold != '0) hold <= hold - 1'b1;
        if (accept) begin
          wptr  <= wptr_nx;
          wgray <= wptr_nx ^ (wptr_nx >> 1);
        end
      end
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_pull,
  input  logic [PW-1:0]     wgray_s,
  input  logic              flush_tog_s,
  input  logic              init_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rgray,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ufl_tog,
  output logic              rd_empty
);
  logic [PW-1:0] rptr, rptr_nx, wbin;
  logic          tog_q, fl, active;
  logic [1:0]    blk;

  for (genvar i = 0; i < PW; i++) begin : g_wr_g2b
    assign wbin[i] = ^(wgray_s >> i);
  end

  assign fl       = flush_tog_s ^ tog_q;
  assign active   = init_s && (blk == 2'd0) && !fl;
  assign rd_empty = (rptr == wbin);
  assign raddr    = rptr[AW-1:0];
  assign rptr_nx  = rptr + 1'b1;

  always_ff @(posedge rd_clk) begin
    if (!rd_rst_n) begin
      tog_q    <= 1'b0;
      blk      <= 2'd0;
      rptr     <= '0;
      rgray    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      ufl_tog  <= 1'b0;
    end else begin
      tog_q    <= flush_tog_s;
      rd_valid <= 1'b0;
      if (fl) begin
        rptr  <= '0;
        rgray <= '0;
        blk   <= 2'd3;
      end else begin
        if (blk != 2'd0) blk <= blk - 2'd1;
        if (rd_pull && active) begin
          if (!rd_empty) begin
            rd_data  <= mem_rdata;
            rd_valid <= 1'b1;
            rptr     <= rptr_nx;
            rgray    <= rptr_nx ^ (rptr_nx >> 1);
          end else begin
            ufl_tog <= ~ufl_tog;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dcf_spill_ctl.sv
`timescale 1ns/1ps
module dcf_spill_ctl
  import dcf_pkg::*;
(
  input  logic wr_clk,
  input  logic wr_rst_n,
  input  logic ovf_evt,
  input  logic ufl_tog_s,
  input  logic new_align,
  input  logic bypass,
  input  logic auto_en,
  input  logic act_sel,
  input  logic lock_gate,
  input  logic async_map,
  input  logic pll_lock,
  input  logic rll_lock,
  input  logic irq_mask,
  input  logic sts_clr,
  output logic spill_sts,
  output logic spill_irq,
  output logic nfa_req,
  output logic flush
);
  logic ufl_q, ufl_evt, spill, locked, fire, realign;

  assign ufl_evt   = ufl_tog_s ^ ufl_q;
  assign spill     = ovf_evt || ufl_evt;
  assign locked    = (lock_src_e'(async_map) == LOCK_SRC_RLL) ? rll_lock : pll_lock;
  assign fire      = spill && auto_en && (!lock_gate || locked);
  assign realign   = (spill_act_e'(act_sel) == SPILL_ACT_REALIGN);
  assign flush     = (fire && !realign) || (new_align && !bypass);
  assign spill_irq = spill_sts && !irq_mask;

  always_ff @(posedge wr_clk) begin
    if (!wr_rst_n) begin
      ufl_q     <= 1'b0;
      spill_sts <= 1'b0;
      nfa_req   <= 1'b0;
    end else begin
      ufl_q   <= ufl_tog_s;
      nfa_req <= fire && realign;
      if (spill)        spill_sts <= 1'b1;
      else if (sts_clr) spill_sts <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_clock_spill_fifo.sv
`timescale 1ns/1ps
module dual_clock_spill_fifo #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned FLUSH_HOLD = 12,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_pull,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              new_align,
  input  logic              bypass,
  input  logic              auto_en,
  input  logic              act_sel,
  input  logic              lock_gate,
  input  logic              async_map,
  input  logic              pll_lock,
  input  logic              rll_lock,
  input  logic              irq_mask,
  input  logic              sts_clr,
  output logic              spill_sts,
  output logic              spill_irq,
  output logic              nfa_req
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              mem_we;
  logic [AW-1:0]     mem_addr, raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [PW-1:0]     wgray, wgray_r, rgray, rgray_w, wptr_w;
  logic              ovf_evt, flush_w, init_done, flush_tog;
  logic              ufl_tog, ufl_tog_w, rd_empty_r;
  logic [1:0]        ctl_r;

  always_ff @(posedge wr_clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end
  assign mem_rdata = mem[raddr];

  dcf_sync #(.W(PW)) u_rptr_sync (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_w));
  dcf_sync #(.W(PW)) u_wptr_sync (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_r));
  dcf_sync #(.W(2))  u_ctl_sync  (.clk(rd_clk), .rst_n(rd_rst_n),
                                  .d({flush_tog, init_done}), .q(ctl_r));
  dcf_sync #(.W(1))  u_ufl_sync  (.clk(wr_clk), .rst_n(wr_rst_n), .d(ufl_tog), .q(ufl_tog_w));

  dcf_wr_side #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FLUSH_HOLD(FLUSH_HOLD)) u_wr (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rgray_s(rgray_w), .flush(flush_w), .wr_ready(wr_ready), .ovf_evt(ovf_evt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wgray(wgray),
    .wptr(wptr_w), .init_done(init_done), .flush_tog(flush_tog)
  );

  dcf_rd_side #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_pull(rd_pull), .wgray_s(wgray_r),
    .flush_tog_s(ctl_r[1]), .init_s(ctl_r[0]), .mem_rdata(mem_rdata), .raddr(raddr),
    .rgray(rgray), .rd_valid(rd_valid), .rd_data(rd_data), .ufl_tog(ufl_tog),
    .rd_empty(rd_empty_r)
  );

  dcf_spill_ctl u_ctl (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .ovf_evt(ovf_evt), .ufl_tog_s(ufl_tog_w),
    .new_align(new_align), .bypass(bypass), .auto_en(auto_en), .act_sel(act_sel),
    .lock_gate(lock_gate), .async_map(async_map), .pll_lock(pll_lock),
    .rll_lock(rll_lock), .irq_mask(irq_mask), .sts_clr(sts_clr),
    .spill_sts(spill_sts), .spill_irq(spill_irq), .nfa_req(nfa_req), .flush(flush_w)
  );
endmodule

// File: rtl/dcf_checker.sv
`timescale 1ns/1ps
module dcf_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = 5
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [PW-1:0] wptr,
  input logic          flush,
  input logic          rd_pull,
  input logic          rd_empty,
  input logic          rd_valid,
  input logic          spill_sts,
  input logic          sts_clr,
  input logic          spill_irq,
  input logic          irq_mask,
  input logic          nfa_req,
  input logic          auto_en,
  input logic          act_sel,
  input logic          lock_gate,
  input logic          async_map,
  input logic          pll_lock,
  input logic          rll_lock
);
  logic [PW:0] cyc;

  always_ff @(posedge wr_clk) begin
    if (!wr_rst_n)                    cyc <= '0;
    else if (cyc < (PW+1)'(DEPTH))    cyc <= cyc + 1'b1;
  end

  assert_fill_blocks_write_R1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (cyc < (PW+1)'(DEPTH)) |-> !wr_ready);

  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!(wr_valid && wr_ready) && !flush) |=> (wptr == $past(wptr)));

  assert_empty_pull_invalid_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_pull && rd_empty) |=> !rd_valid);

  assert_status_sticky_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (spill_sts && !sts_clr) |=> spill_sts);

  assert_irq_masked_R6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    irq_mask |-> !spill_irq);

  assert_realign_enabled_R7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    nfa_req |-> $past(auto_en && act_sel));

  assert_flush_zeroes_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    flush |=> (wptr == '0));

  assert_lock_gated_R10: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    nfa_req |-> $past(!lock_gate || (async_map ? rll_lock : pll_lock)));
endmodule

bind dual_clock_spill_fifo dcf_checker #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wptr(wptr_w), .flush(flush_w),
  .rd_pull(rd_pull), .rd_empty(rd_empty_r), .rd_valid(rd_valid),
  .spill_sts(spill_sts), .sts_clr(sts_clr), .spill_irq(spill_irq), .irq_mask(irq_mask),
  .nfa_req(nfa_req), .auto_en(auto_en), .act_sel(act_sel), .lock_gate(lock_gate),
  .async_map(async_map), .pll_lock(pll_lock), .rll_lock(rll_lock)
);

// File: tb/test_dual_clock_spill_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_spill_fifo;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_pull = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic new_align = 1'b0, bypass = 1'b0, auto_en = 1'b0, act_sel = 1'b0;
  logic lock_gate = 1'b0, async_map = 1'b0, pll_lock = 1'b0, rll_lock = 1'b0;
  logic irq_mask = 1'b0, sts_clr = 1'b0;
  logic wr_ready, rd_valid, spill_sts, spill_irq, nfa_req;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_bad = 0, rx_cnt = 0, nfa_cnt = 0;
  logic [DW-1:0] sb[$];
  bit wdone;

  always #2.5 wclk = ~wclk;
  always #3   rclk = ~rclk;

  dual_clock_spill_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .FLUSH_HOLD(12)) i_dual_clock_spill_fifo (
    .wr_clk(wclk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_clk(rclk), .rd_rst_n(rd_rst_n), .rd_pull(rd_pull),
    .rd_valid(rd_valid), .rd_data(rd_data), .new_align(new_align), .bypass(bypass),
    .auto_en(auto_en), .act_sel(act_sel), .lock_gate(lock_gate), .async_map(async_map),
    .pll_lock(pll_lock), .rll_lock(rll_lock), .irq_mask(irq_mask), .sts_clr(sts_clr),
    .spill_sts(spill_sts), .spill_irq(spill_irq), .nfa_req(nfa_req)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2 scoreboard: accepted words in, delivered words out
  always @(posedge wclk) if (wr_rst_n && wr_valid && wr_ready) sb.push_back(wr_data);
  always @(posedge wclk) if (wr_rst_n && nfa_req) nfa_cnt++;
  always @(negedge rclk) begin
    if (rd_rst_n && rd_valid) begin
      rx_cnt++;
      if (sb.size() == 0) check("R2 unexpected word", 1, 0);
      else check("R2 order", rd_data, sb.pop_front());
    end
  end

  task automatic wcyc(int n); repeat (n) @(negedge wclk); endtask
  task automatic rcyc(int n); repeat (n) @(negedge rclk); endtask

  task automatic push_word();
    @(negedge wclk);
    while (!wr_ready) @(negedge wclk);
    wr_valid = 1'b1;
    wr_data  = DW'($urandom);
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  task automatic overflow_pulse(string req);
    @(negedge wclk);
    check({req, " full before offer"}, wr_ready, 0);
    wr_valid = 1'b1;
    wr_data  = 16'hDEAD;
    @(negedge wclk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge rclk);
    for (int g = 0; g < 2000 && sb.size() > 0; g++) begin
      rd_pull = 1'b1;
      @(negedge rclk);
    end
    rd_pull = 1'b0;
  endtask

  task automatic settle_clear();
    wcyc(12);
    sts_clr = 1'b1;
    wcyc(1);
    sts_clr = 1'b0;
    wcyc(2);
    check("R5 status cleared", spill_sts, 0);
  endtask

  task automatic pull_window_empty(string req);
    int rx0;
    rx0 = rx_cnt;
    @(negedge rclk);
    rd_pull = 1'b1;
    rcyc(6);
    rd_pull = 1'b0;
    rcyc(2);
    check(req, rx_cnt - rx0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n0, rx0;
    logic [DW-1:0] held;
    void'($urandom(32'd2024));
    wcyc(6);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;

    // R1: clearing phase blocks writes
    wcyc(1);
    check("R1 ready low in clear", wr_ready, 0);
    wcyc(DEPTH - 4);
    check("R1 ready low late in clear", wr_ready, 0);
    check("R1 rd_valid idle", rd_valid, 0);
    check("R1 rd_data zero", rd_data, 0);
    check("R1 status zero", spill_sts, 0);
    wcyc(6);
    check("R1 ready after clear", wr_ready, 1);

    // R2: random streaming, no recovery
    wdone = 1'b0;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          if ($urandom % 4 == 0) wcyc(1 + $urandom % 3);
          push_word();
        end
        wdone = 1'b1;
      end
      begin
        while (!(wdone && sb.size() == 0)) begin
          @(negedge rclk);
          rd_pull = ($urandom % 3) != 0;
        end
        rd_pull = 1'b0;
      end
    join
    check("R2 words delivered", rx_cnt, 300);
    settle_clear();

    // R4: pull on empty
    held = rd_data;
    @(negedge rclk);
    rd_pull = 1'b1;
    @(negedge rclk);
    rd_pull = 1'b0;
    check("R4 no valid on empty", rd_valid, 0);
    check("R4 data held", rd_data, held);
    wcyc(12);
    check("R4 underflow sets status", spill_sts, 1);
    check("R6 irq follows status", spill_irq, 1);
    @(negedge wclk);
    irq_mask = 1'b1;
    #1;
    check("R6 irq masked", spill_irq, 0);
    irq_mask = 1'b0;
    settle_clear();

    // R3 / R9: overflow with recovery off
    n0 = nfa_cnt;
    repeat (DEPTH) push_word();
    overflow_pulse("R3");
    wcyc(20);
    check("R3 overflow sets status", spill_sts, 1);
    check("R9 no realign when disabled", nfa_cnt - n0, 0);
    check("R9 no flush when disabled", wr_ready, 0);
    check("R3 stored count", sb.size(), DEPTH);
    rx0 = rx_cnt;
    drain();
    check("R3 dropped word absent", rx_cnt - rx0, DEPTH);
    settle_clear();

    // R7: realign request
    auto_en = 1'b1; act_sel = 1'b1;
    n0 = nfa_cnt;
    repeat (DEPTH) push_word();
    overflow_pulse("R7");
    wcyc(6);
    check("R7 one realign pulse", nfa_cnt - n0, 1);
    check("R7 contents kept", wr_ready, 0);
    auto_en = 1'b0;
    rx0 = rx_cnt;
    drain();
    check("R7 words intact", rx_cnt - rx0, DEPTH);
    settle_clear();

    // R10: lock gating and source select
    auto_en = 1'b1; act_sel = 1'b1; lock_gate = 1'b1;
    async_map = 1'b1; pll_lock = 1'b1; rll_lock = 1'b0;
    n0 = nfa_cnt;
    repeat (DEPTH) push_word();
    overflow_pulse("R10");
    wcyc(6);
    check("R10 blocked without rll lock", nfa_cnt - n0, 0);
    async_map = 1'b0;
    overflow_pulse("R10");
    wcyc(6);
    check("R10 fires with pll lock", nfa_cnt - n0, 1);
    auto_en = 1'b0; lock_gate = 1'b0;
    drain();
    settle_clear();

    // R8: pointer reset action
    auto_en = 1'b1; act_sel = 1'b0;
    repeat (DEPTH) push_word();
    overflow_pulse("R8");
    wcyc(2);
    check("R8 hold blocks writes", wr_ready, 0);
    wcyc(30);
    check("R8 ready after flush", wr_ready, 1);
    sb.delete();
    auto_en = 1'b0;
    pull_window_empty("R8 flushed words gone");
    repeat (3) push_word();
    rx0 = rx_cnt;
    wcyc(6);
    drain();
    check("R8 traffic resumes", rx_cnt - rx0, 3);
    settle_clear();

    // R11: alignment events with and without bypass
    bypass = 1'b0;
    repeat (4) push_word();
    wcyc(10);
    @(negedge wclk); new_align = 1'b1;
    @(negedge wclk); new_align = 1'b0;
    wcyc(30);
    sb.delete();
    check("R11 ready after align flush", wr_ready, 1);
    pull_window_empty("R11 align flushes");
    settle_clear();
    bypass = 1'b1;
    repeat (4) push_word();
    wcyc(10);
    @(negedge wclk); new_align = 1'b1;
    @(negedge wclk); new_align = 1'b0;
    wcyc(30);
    rx0 = rx_cnt;
    drain();
    check("R11 bypass keeps words", rx_cnt - rx0, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule